// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small file of processor control registers that software reaches through two I/O ports. A write to the index port (22h) selects a register. The next access to the data port (23h) reads or writes that register. The block watches every cycle on a synchronous I/O bus. For each cycle it decides whether the cycle is claimed internally or must go out to the system as an external I/O cycle.

A selected index can be used for one data-port access only. After that access the selection is used up, and any further data-port access goes out on the external bus until software writes a new index. Part of the index space is hidden behind a 4-bit unlock field that lives in one of the block's own registers. The registers in that hidden range can be reached only while that field holds exactly 1h. Two control values drive outputs: the unlock field and the instruction-identification enable bit.

Top module: `idx_cfg_port`

## Requirements
- R1: After reset every register reads 00h, `cpuid_en` is 0, `map_unlock` is 0h, and no index is armed, so a first data-port access is external (`ext_cycle`=1).
- R2: A write to port 22h whose index is implemented and reachable is claimed (`ext_cycle`=0) and arms exactly one following port-23h access.
- R3: An armed port-23h write stores the data, and an armed port-23h read returns the stored value. Both are claimed. Reserved bits read as 0 and ignore writes: bit 3 of index C3h, and bits 6:3 of index E8h.
- R4: A port-23h access without a fresh index write (for example, the second of two) has `ext_cycle`=1 and leaves every register unchanged.
- R5: Every read of port 22h has `ext_cycle`=1 and `io_rdata`=00h.
- R6: Indexes E8h, E9h and EAh are reachable only while bits 7:4 of index C3h equal 1h. With any other value, the index write and the port-23h access after it are both external.
- R7: An index that is not implemented makes its index write and the following port-23h access external. The implemented indexes are C0h, C1h, C2h, C3h, E8h, E9h and EAh.
- R8: `cpuid_en` follows bit 7 of index E8h, and `map_unlock` follows bits 7:4 of index C3h.
- R9: A valid cycle to any address other than 22h or 23h has `ext_cycle`=1. With `io_valid` low, `ext_cycle` is 0.
- R10: `io_rdata` is 00h on every cycle that is not a claimed port-23h read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | I/O bus cycle present this clock |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational, same cycle) |
| ext_cycle | output | 1 | Cycle not claimed; pass to external bus (same cycle) |
| cpuid_en | output | 1 | Instruction-identification enable |
| map_unlock | output | 4 | Current unlock field value |

## Verification
The assertions run on every cycle. They check that index-port reads always go external and return zero data, that two data-port accesses in a row never both get claimed, and that hidden indexes stay external while the unlock field is not 1h. They also check that the output bits change only on a data-port write, and that idle cycles never raise `ext_cycle`. The values written and read back can only be shown by the bench scenarios. These include the masking of reserved bits, the fact that a leaked write leaves storage untouched, and the locking that takes effect again once the unlock field moves away from 1h.

// File: rtl/cfgp_pkg.sv
// Package: shared constants and the reachability rule for the configuration port.
// Assumes 8-bit indexes and data; register slot order is fixed below.
package cfgp_pkg;
    localparam int DW   = 8;
    localparam int NREG = 7;
    localparam logic [7:0] P_INDEX_PORT = 8'h22;
    localparam logic [7:0] P_DATA_PORT  = 8'h23;
    localparam int SLOT_LOCKREG = 3;   // holds unlock field in 7:4
    localparam int SLOT_IDREG   = 4;   // holds id-enable in bit 7
    localparam logic [NREG-1:0][7:0] REG_IDX  =
        {8'hEA, 8'hE9, 8'hE8, 8'hC3, 8'hC2, 8'hC1, 8'hC0};
    localparam logic [NREG-1:0][7:0] REG_MASK =
        {8'hFF, 8'hFF, 8'h87, 8'hF7, 8'hFF, 8'hFF, 8'hFF};
    localparam logic [3:0] UNLOCK_CODE = 4'h1;

    // True when the index may be reached with the given unlock field.
    function automatic logic idx_reachable(input logic [7:0] idx, input logic [3:0] unl);
        logic always_open;
        always_open = (idx[7:4] == 4'hC) || (idx >= 8'hFC);
        return always_open || ((unl == UNLOCK_CODE) && (idx >= 8'hD0) && (idx <= 8'hFB));
    endfunction
endpackage

// File: rtl/cfgp_decode.sv
// Index decoder: one-hot register select, gated by reachability.
// Assumes the index table in cfgp_pkg holds distinct entries.
module cfgp_decode
    import cfgp_pkg::*;
(
    input  logic [7:0]      idx,
    input  logic [3:0]      unlock,
    output logic [NREG-1:0] sel,
    output logic            hit
);
    logic reach;

    // Reachability of the presented index.
    always_comb reach = idx_reachable(idx, unlock);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_match
            // Select slot g when its index matches and is reachable.
            always_comb sel[g] = reach && (idx == REG_IDX[g]);
        end
    endgenerate

    // Any implemented reachable register selected.
    always_comb hit = |sel;
endmodule

// File: rtl/cfgp_index_latch.sv
// Index holder: stores the last written index and a one-shot armed flag.
// Assumes the caller qualifies the strobes with io_valid.
module cfgp_index_latch
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] idx_in,
    input  logic       idx_ok,
    input  logic       data_acc,
    output logic [7:0] idx_q,
    output logic       armed_q
);
    // Latch index on index writes; arm only for a good index; disarm on data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 8'h00;
            armed_q <= 1'b0;
        end else if (idx_wr) begin
            idx_q   <= idx_in;
            armed_q <= idx_ok;
        end else if (data_acc) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgp_regfile.sv
// Register storage: one masked 8-bit register per slot, OR-mux read.
// Assumes sel is one-hot or zero.
module cfgp_regfile
    import cfgp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NREG-1:0] sel,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            id_enable,
    output logic [3:0]      unlock
);
    logic [NREG-1:0][DW-1:0] regs_q;
    logic [NREG-1:0][DW-1:0] rd_terms;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            // Store writable bits of slot g; reserved bits stay 0.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (wr_en && sel[g])
                    regs_q[g] <= wdata & REG_MASK[g];
            end
            // Read term of slot g.
            always_comb rd_terms[g] = sel[g] ? regs_q[g] : '0;
        end
    endgenerate

    // Combine read terms.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) rdata = rdata | rd_terms[i];
    end

    // Control fields driven out.
    always_comb id_enable = regs_q[SLOT_IDREG][7];
    always_comb unlock    = regs_q[SLOT_LOCKREG][7:4];
endmodule

// File: rtl/idx_cfg_port.sv
// Top: indexed configuration port. Claims index/data port cycles that hit
// internal registers, flags all others as external. Outputs are combinational
// with the bus cycle; state updates at the clock edge.
module idx_cfg_port
    import cfgp_pkg::*;
#(
    parameter logic [7:0] INDEX_PORT = P_INDEX_PORT,
    parameter logic [7:0] DATA_PORT  = P_DATA_PORT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_valid,
    input  logic          io_write,
    input  logic [7:0]    io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          ext_cycle,
    output logic          cpuid_en,
    output logic [3:0]    map_unlock
);
    logic            at_index, at_data, idx_wr, data_acc;
    logic [7:0]      idx_q, dec_idx;
    logic            armed_q, hit, claim;
    logic [NREG-1:0] sel;
    logic [DW-1:0]   rf_rdata;

    // Classify the bus cycle.
    always_comb begin
        at_index = io_valid && (io_addr == INDEX_PORT);
        at_data  = io_valid && (io_addr == DATA_PORT);
        idx_wr   = at_index && io_write;
        data_acc = at_data;
    end

    // Decode new index on index writes, else the held one.
    always_comb dec_idx = idx_wr ? io_wdata : idx_q;

    cfgp_decode u_dec (
        .idx    (dec_idx),
        .unlock (map_unlock),
        .sel    (sel),
        .hit    (hit)
    );

    cfgp_index_latch u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .idx_in   (io_wdata),
        .idx_ok   (hit),
        .data_acc (data_acc),
        .idx_q    (idx_q),
        .armed_q  (armed_q)
    );

    // Claim decision for the current cycle.
    always_comb claim = (idx_wr && hit) || (data_acc && armed_q && hit);

    cfgp_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_acc && armed_q && hit && io_write),
        .sel       (sel),
        .wdata     (io_wdata),
        .rdata     (rf_rdata),
        .id_enable (cpuid_en),
        .unlock    (map_unlock)
    );

    // Bus outputs.
    always_comb begin
        ext_cycle = io_valid && !claim;
        io_rdata  = (claim && data_acc && !io_write) ? rf_rdata : '0;
    end
endmodule

// File: rtl/cfgp_checker.sv
// Checker: cycle properties of the configuration port, bound to the top.
module cfgp_checker #(
    parameter logic [7:0] INDEX_PORT = 8'h22,
    parameter logic [7:0] DATA_PORT  = 8'h23
) (
    input logic       clk,
    input logic       rst_n,
    input logic       io_valid,
    input logic       io_write,
    input logic [7:0] io_addr,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       ext_cycle,
    input logic       cpuid_en,
    input logic [3:0] map_unlock
);
    p_idx_read_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_write && io_addr == INDEX_PORT) |-> (ext_cycle && io_rdata == 8'h00));

    p_second_data_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_addr == DATA_PORT) ##1 (io_valid && io_addr == DATA_PORT) |-> ext_cycle);

    p_locked_idx_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_addr == INDEX_PORT && map_unlock != 4'h1 &&
         io_wdata >= 8'hD0 && io_wdata <= 8'hFB) |-> ext_cycle);

    p_outputs_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && io_write && io_addr == DATA_PORT) |=> ($stable(cpuid_en) && $stable(map_unlock)));

    p_other_addr_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_addr != INDEX_PORT && io_addr != DATA_PORT) |-> ext_cycle);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |-> (!ext_cycle && io_rdata == 8'h00));

    p_ext_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cycle |-> io_rdata == 8'h00);
endmodule

bind idx_cfg_port cfgp_checker #(.INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ext_cycle(ext_cycle), .cpuid_en(cpuid_en), .map_unlock(map_unlock)
);

// File: tb/sim_idx_cfg_port.sv
// Directed bench for idx_cfg_port.
module sim_idx_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_valid = 1'b0;
    logic       io_write = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       ext_cycle;
    logic       cpuid_en;
    logic [3:0] map_unlock;
    int checks = 0;
    int failures = 0;
    logic       s_ext;
    logic [7:0] s_rd;

    always #2 clk = ~clk;

    idx_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ext_cycle(ext_cycle), .cpuid_en(cpuid_en), .map_unlock(map_unlock)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; samples the combinational outputs before the edge.
    task automatic bus(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_addr = a; io_wdata = d;
        #1;
        s_ext = ext_cycle; s_rd = io_rdata;
        @(posedge clk);
        #1;
        io_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        bus(1'b1, 8'h22, idx);
        bus(1'b1, 8'h23, d);
    endtask

    task automatic rd_reg(input logic [7:0] idx, input string req, input int exp);
        bus(1'b1, 8'h22, idx);
        bus(1'b0, 8'h23, 8'h00);
        check(req, s_rd, exp);
    endtask

    task automatic t_reset;
        check("R1 unlock", map_unlock, 0);
        check("R1 cpuid", cpuid_en, 0);
        bus(1'b0, 8'h23, 8'h00);
        check("R1 unarmed data ext", s_ext, 1);
        rd_reg(8'hC0, "R1 C0 zero", 8'h00);
        rd_reg(8'hE9, "R1 E9 reads 0 (locked)", 8'h00);
    endtask

    task automatic t_basic;
        bus(1'b1, 8'h22, 8'hC0);
        check("R2 index claim", s_ext, 0);
        bus(1'b1, 8'h23, 8'hA5);
        check("R3 data write claim", s_ext, 0);
        rd_reg(8'hC0, "R3 C0 readback", 8'hA5);
        check("R3 read claim", s_ext, 0);
        wr_reg(8'hC3, 8'hEF);
        rd_reg(8'hC3, "R3 C3 reserved bit3", 8'hE7);
        check("R8 unlock follows", map_unlock, 4'hE);
    endtask

    task automatic t_repeat;
        wr_reg(8'hC1, 8'h11);
        bus(1'b1, 8'h23, 8'h22);
        check("R4 second data ext", s_ext, 1);
        bus(1'b0, 8'h23, 8'h00);
        check("R4 repeat read ext", s_ext, 1);
        check("R10 ext read data", s_rd, 0);
        rd_reg(8'hC1, "R4 leaked write no effect", 8'h11);
    endtask

    task automatic t_idx_read;
        bus(1'b1, 8'h22, 8'hC2);
        bus(1'b0, 8'h22, 8'h00);
        check("R5 index read ext", s_ext, 1);
        check("R5 index read data", s_rd, 0);
    endtask

    task automatic t_unlock;
        bus(1'b1, 8'h22, 8'hE8);
        check("R6 E8 locked (unlock E)", s_ext, 1);
        bus(1'b1, 8'h23, 8'hFF);
        check("R6 data after locked ext", s_ext, 1);
        check("R6 cpuid unchanged", cpuid_en, 0);
        wr_reg(8'hC3, 8'h10);
        check("R8 unlock 1", map_unlock, 1);
        bus(1'b1, 8'h22, 8'hE8);
        check("R6 E8 open", s_ext, 0);
        bus(1'b1, 8'h23, 8'hFF);
        check("R8 cpuid set", cpuid_en, 1);
        rd_reg(8'hE8, "R3 E8 reserved bits", 8'h87);
        wr_reg(8'hEA, 8'h5C);
        rd_reg(8'hEA, "R6 EA open rw", 8'h5C);
        wr_reg(8'hC3, 8'h20);
        bus(1'b1, 8'h22, 8'hEA);
        check("R6 relocked (unlock 2)", s_ext, 1);
        check("R8 cpuid held", cpuid_en, 1);
    endtask

    task automatic t_unimpl;
        bus(1'b1, 8'h22, 8'hC5);
        check("R7 C5 index ext", s_ext, 1);
        bus(1'b1, 8'h23, 8'h33);
        check("R7 C5 data ext", s_ext, 1);
        bus(1'b1, 8'h22, 8'hFC);
        check("R7 FC index ext", s_ext, 1);
        wr_reg(8'hC3, 8'h10);
        bus(1'b1, 8'h22, 8'hD0);
        check("R7 D0 unlocked but absent", s_ext, 1);
        bus(1'b0, 8'h23, 8'h00);
        check("R7 D0 data ext", s_ext, 1);
    endtask

    task automatic t_other;
        bus(1'b1, 8'h80, 8'h01);
        check("R9 other addr ext", s_ext, 1);
        bus(1'b0, 8'h24, 8'h00);
        check("R9 other read ext", s_ext, 1);
        check("R10 other read data", s_rd, 0);
        @(negedge clk); #1;
        check("R9 idle no ext", ext_cycle, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_repeat();
        t_idx_read();
        t_unlock();
        t_unimpl();
        t_other();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule